// File: doc/BRIEF.md
# Programmable Tap-Select Divider Timer

This block is a synchronous timer around a sixteen-stage binary counter. The counter advances by one on every system clock cycle in which the count strobe is high. The output is taken from one of four counter stages, chosen by a two-bit select: stage 8, 10, 13 or 16. The timer has two modes. In recycle mode the chosen stage drives the output directly, so the output is a square wave at the strobe rate divided by two to the power of the stage number. In single-transition mode the output switches once, after half of the selected period has been counted. It then holds until the timer is reset again.

A master reset input clears the counter and the single-transition latch, and counting is held off for as long as it stays high. After the synchronous system reset releases, an internal power-on sequencer asserts its own reset for a few cycles, but only if the auto-reset input is low. If the auto-reset input is high, the timer stays unarmed and ignores strobes until the first master reset pulse. A polarity input inverts the output, so it can rest either low or high after reset.

Top module: `tap_timer`

## Requirements
- R1: Once the timer is armed and no internal reset is active, the counter advances by exactly one for every clock cycle with `cnt_en` high. After 65535 it wraps to 0.
- R2: The select picks the output stage N as follows. `tap_sel`=2'b00 gives N=13, 2'b01 gives N=10, 2'b10 gives N=8 and 2'b11 gives N=16. The stage value is counter bit N-1.
- R3: With `recycle`=1, the true-polarity output equals counter bit N-1. It is therefore low for the first 2^(N-1) counts after a reset, then high for 2^(N-1) counts, and the pattern repeats.
- R4: With `recycle`=0, the true-polarity output rises once 2^(N-1) counts have passed since reset. It then stays high, including after the counter wraps, until an internal reset or until `recycle` goes to 1.
- R5: While `mreset` is high, the counter and the latch are cleared on every clock and strobes are ignored. Counting resumes on the first strobe after `mreset` falls.
- R6: `invert`=1 inverts the output. In the cycle after any internal reset, `tmr_out` equals `invert`.
- R7: After `rst` falls, an internal reset is applied for AR_LEN (default 4) cycles if `auto_off`=0, and that reset arms the timer. With `auto_off`=1, strobes are ignored until a master reset has been applied.
- R8: A new `tap_sel` value takes effect at the next accepted strobe, or at an internal reset. It does not clear the counter.
- R9: While `recycle`=1 the latch is cleared. After a return to `recycle`=0, the output again follows R4 from the current count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_en | input | 1 | Count strobe, one count per high cycle |
| mreset | input | 1 | Master reset, active high |
| auto_off | input | 1 | 1 disables the power-on auto-reset |
| tap_sel | input | 2 | Output stage select |
| recycle | input | 1 | 1 = recycle divider, 0 = single transition |
| invert | input | 1 | Output polarity, 1 = inverted |
| tmr_out | output | 1 | Timer output |

## Verification
The assertions assume that every input is synchronous to `clk` and stable across the sampling edge. They also assume that `cnt_en` is a level sampled once per cycle, not an edge, so that one high cycle counts exactly once. The stimulus changes inputs only a fixed delay after each rising edge. It pulses `mreset` for whole cycles and keeps `rst` high for several cycles, so the power-on sequencer always starts from its loaded value. Strobe trains are dense, or gapped at regular intervals. Select and mode changes are placed mid-count, to exercise the deferred select update and the clearing of the latch.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;

    localparam int unsigned TAP_STAGES = 16;

    typedef enum logic [1:0] {
        SEL_S13 = 2'b00,
        SEL_S10 = 2'b01,
        SEL_S8  = 2'b10,
        SEL_S16 = 2'b11
    } tap_sel_e;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_RECYCLE = 1'b1
    } tmr_mode_e;

    typedef struct packed {
        logic clr;
        logic step;
    } cnt_ctl_t;

    function automatic int unsigned tap_stage(input tap_sel_e s);
        case (s)
            SEL_S13: return 13;
            SEL_S10: return 10;
            SEL_S8:  return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/tap_por_seq.sv
module tap_por_seq #(
    parameter int unsigned AR_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic auto_off,
    input  logic mreset,
    output logic int_rst,
    output logic armed
);
    localparam int unsigned PW = $clog2(AR_LEN + 1);

    logic [PW-1:0] por_q;
    logic          por_live;

    assign por_live = (por_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            por_q <= PW'(AR_LEN);
        end else if (por_live) begin
            por_q <= por_q - 1'b1;
        end
    end

    assign int_rst = mreset | (por_live & ~auto_off);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (int_rst) begin
            armed <= 1'b1;
        end
    end

    // R7: once armed, only the system reset disarms
    p_arm_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);

    // R7: an internal reset always leaves the timer armed
    p_arm_after_reset_r7: assert property (@(posedge clk) disable iff (rst)
        int_rst |=> armed);

endmodule

// File: rtl/tap_ripple_counter.sv
module tap_ripple_counter
    import tap_timer_pkg::*;
#(
    parameter int unsigned STAGES = TAP_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_ctl_t          ctl,
    output logic [STAGES-1:0] q
);
    logic [STAGES-1:0] carry;

    assign carry[0] = ctl.step;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            logic stage_q;

            always_ff @(posedge clk) begin
                if (rst || ctl.clr) begin
                    stage_q <= 1'b0;
                end else if (carry[i]) begin
                    stage_q <= ~stage_q;
                end
            end

            assign q[i] = stage_q;

            if (i < STAGES - 1) begin : g_carry
                assign carry[i+1] = carry[i] & stage_q;
            end
        end
    endgenerate

    // R1: one accepted strobe adds exactly one, modulo 2^STAGES
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && !ctl.clr) |=> (q == $past(q) + 1'b1));

    // R5: a clear leaves the counter at zero
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (q == '0));

    // R5: no strobe, no movement
    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctl.step && !ctl.clr) |=> $stable(q));

endmodule

// File: rtl/tap_out_stage.sv
module tap_out_stage
    import tap_timer_pkg::*;
#(
    parameter int unsigned STAGES = TAP_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  logic [1:0]        sel,
    input  logic              mode,
    input  logic              pol,
    input  logic [STAGES-1:0] cnt,
    output logic              tmr_out
);
    localparam int unsigned IW = $clog2(STAGES);

    tap_sel_e  sel_q;
    tmr_mode_e mode_e;
    logic [IW-1:0] idx;
    logic          tap_bit;
    logic          fired_q;

    assign mode_e = tmr_mode_e'(mode);

    // R8: select is sampled only at accepted strobes or resets
    always_ff @(posedge clk) begin
        if (rst || clr || step) begin
            sel_q <= tap_sel_e'(sel);
        end
    end

    always_comb begin
        int unsigned st;
        st = tap_stage(sel_q);
        if (st > STAGES) begin
            st = STAGES;
        end
        idx = IW'(st - 1);
    end

    assign tap_bit = cnt[idx];

    // R4, R9: single-transition latch
    always_ff @(posedge clk) begin
        if (rst || clr || (mode_e == MODE_RECYCLE)) begin
            fired_q <= 1'b0;
        end else if (tap_bit) begin
            fired_q <= 1'b1;
        end
    end

    always_comb begin
        logic level;
        if (mode_e == MODE_RECYCLE) begin
            level = tap_bit;
        end else begin
            level = fired_q | tap_bit;
        end
        tmr_out = pol ^ level;
    end

    // R4: latch holds through counter wrap
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (fired_q && (mode_e == MODE_ONESHOT) && !clr) |=> fired_q);

    // R8: select register only moves at a strobe or reset
    p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(sel_q));

    // R9: recycle mode leaves the latch empty
    p_latch_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_RECYCLE) |=> !fired_q);

endmodule

// File: rtl/tap_timer.sv
module tap_timer
    import tap_timer_pkg::*;
#(
    parameter int unsigned STAGES = TAP_STAGES,
    parameter int unsigned AR_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    input  logic       mreset,
    input  logic       auto_off,
    input  logic [1:0] tap_sel,
    input  logic       recycle,
    input  logic       invert,
    output logic       tmr_out
);
    logic              int_rst;
    logic              armed;
    cnt_ctl_t          ctl;
    logic [STAGES-1:0] cnt;

    tap_por_seq #(.AR_LEN(AR_LEN)) u_por (
        .clk      (clk),
        .rst      (rst),
        .auto_off (auto_off),
        .mreset   (mreset),
        .int_rst  (int_rst),
        .armed    (armed)
    );

    // count strobe is gated off during any reset and before arming
    assign ctl.clr  = int_rst;
    assign ctl.step = cnt_en & armed & ~int_rst;

    tap_ripple_counter #(.STAGES(STAGES)) u_cnt (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .q   (cnt)
    );

    tap_out_stage #(.STAGES(STAGES)) u_out (
        .clk     (clk),
        .rst     (rst),
        .clr     (int_rst),
        .step    (ctl.step),
        .sel     (tap_sel),
        .mode    (recycle),
        .pol     (invert),
        .cnt     (cnt),
        .tmr_out (tmr_out)
    );

    // R6: output rests at the polarity level right after a reset
    p_rst_out_r6: assert property (@(posedge clk) disable iff (rst)
        int_rst |=> (tmr_out == invert));

    // R7: an unarmed timer does not count
    p_unarmed_r7: assert property (@(posedge clk) disable iff (rst)
        (!armed && !int_rst) |=> (cnt == '0));

endmodule

// File: tb/sim_tap_timer.sv
`timescale 1ns/1ps
module sim_tap_timer;
    localparam int AR = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       mreset = 1'b0;
    logic       auto_off = 1'b0;
    logic [1:0] tap_sel = 2'b00;
    logic       recycle = 1'b1;
    logic       invert = 1'b0;
    logic       tmr_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string phase = "R6 reset";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    tap_timer #(.AR_LEN(AR)) u0 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .mreset(mreset),
        .auto_off(auto_off), .tap_sel(tap_sel), .recycle(recycle),
        .invert(invert), .tmr_out(tmr_out)
    );

    // behavioural reference
    int       m_cnt, m_por, m_n;
    bit       m_latch, m_armed, m_irst, m_b;
    bit [1:0] m_sel;

    function automatic int stage_of(bit [1:0] s);
        case (s)
            2'b00: return 13;
            2'b01: return 10;
            2'b10: return 8;
            default: return 16;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt = 0; m_latch = 0; m_armed = 0; m_por = AR; m_sel = tap_sel;
        end else begin
            m_irst = mreset || (m_por > 0 && !auto_off);
            if (m_por > 0) m_por--;
            if (m_irst) begin
                m_cnt = 0; m_latch = 0; m_armed = 1; m_sel = tap_sel;
            end else begin
                m_b = ((m_cnt >> (stage_of(m_sel) - 1)) & 1) != 0;
                if (recycle) m_latch = 0;
                else if (m_b) m_latch = 1;
                if (m_armed && cnt_en) begin
                    m_cnt = (m_cnt + 1) % 65536;
                    m_sel = tap_sel;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit b, exp;
            b = ((m_cnt >> (stage_of(m_sel) - 1)) & 1) != 0;
            exp = invert ^ (recycle ? b : (m_latch | b));
            n_cmp++;
            if (tmr_out !== exp) begin
                n_bad++;
                if (n_bad < 20)
                    $display("FAIL %s: cycle %0d tmr_out=%0b expected %0b (count %0d)",
                             phase, cyc, tmr_out, exp, m_cnt);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 195000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: cycle %0d actual running expected finished", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #4;
    endtask

    task automatic mr_pulse();
        mreset = 1'b1;
        wait_cyc(2);
        mreset = 1'b0;
    endtask

    task automatic do_reset(bit aoff);
        rst = 1'b1; auto_off = aoff;
        wait_cyc(3);
        rst = 1'b0;
    endtask

    initial begin
        wait_cyc(1);
        // R6 R7: power-on auto-reset arms the timer
        phase = "R6 R7 auto-reset on";
        cnt_en = 1'b1; recycle = 1'b1; tap_sel = 2'b10;
        do_reset(1'b0);
        wait_cyc(300);

        // R7: auto-reset disabled, strobes ignored until master reset
        phase = "R7 auto-reset off";
        do_reset(1'b1);
        wait_cyc(100);
        mr_pulse();
        wait_cyc(300);

        // R2 R3 R6: recycle mode, three short taps, both polarities
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 3; s++) begin
                phase = "R2 R3 R6 recycle";
                invert = p[0]; tap_sel = s[1:0]; recycle = 1'b1;
                mr_pulse();
                wait_cyc((1 << stage_of(s[1:0])) + 100);
            end
        end

        // R2 R4 R6: single-transition, three short taps, both polarities
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 3; s++) begin
                phase = "R2 R4 R6 single";
                invert = p[0]; tap_sel = s[1:0]; recycle = 1'b0;
                mr_pulse();
                wait_cyc((1 << stage_of(s[1:0])) + 100);
            end
        end

        // R1 R4: stage 16 single transition through a full wrap
        phase = "R1 R4 wrap";
        invert = 1'b0; tap_sel = 2'b11; recycle = 1'b0;
        mr_pulse();
        wait_cyc(65536 + 200);

        // R2 R3: stage 16 recycle, inverted
        phase = "R2 R3 stage16";
        invert = 1'b1; recycle = 1'b1;
        mr_pulse();
        wait_cyc(32900);

        // R1 R8: gapped strobes, select change mid-count
        phase = "R1 R8 select change";
        invert = 1'b0; tap_sel = 2'b10;
        mr_pulse();
        for (int k = 0; k < 200; k++) begin
            cnt_en = k[0];
            if (k == 90) tap_sel = 2'b01;
            if (k == 150) tap_sel = 2'b10;
            wait_cyc(1);
        end
        cnt_en = 1'b1;
        wait_cyc(700);

        // R9: mode flip clears the latch
        phase = "R9 mode flip";
        recycle = 1'b0; tap_sel = 2'b10;
        mr_pulse();
        wait_cyc(200);
        recycle = 1'b1;
        wait_cyc(20);
        recycle = 1'b0;
        wait_cyc(300);

        // R5: long master reset with strobes on, and mid-count reset
        phase = "R5 master reset";
        mreset = 1'b1;
        wait_cyc(50);
        mreset = 1'b0;
        wait_cyc(100);
        mr_pulse();
        wait_cyc(200);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule